// File: doc/BRIEF.md
# Synonym Value Store with Producer Rename Map

This block holds the speculative values that predicted producer instructions hand to predicted consumer instructions. Both sides find each other only through a synonym, a small identifier given out by a dependence predictor. A producer may be a load that starts a read-after-read pair or a store that starts a read-after-write pair. When it is predicted, it reserves a slot for its synonym. When its value arrives, it fills that slot. If the value will sit in a physical register for a while, the producer also records that register in a small rename map. When the producer commits, it removes that mapping.

A consumer presents a synonym and gets an answer in the same cycle. The block searches the rename map and the value store at the same time. A mapping redirects the consumer to the producer's physical register. Otherwise a filled slot supplies the value. Otherwise the consumer is told that nothing is available and goes on without a speculative value. The value store is two-way set associative and is indexed by the low bits of the synonym. The rename map is fully associative. Prediction, verification of the speculated value, and recovery all live outside this block.

Top module: `synonym_value_store`

## Requirements
- R1: After reset, every consumer lookup returns kind 0 (nothing available), whatever synonym it presents.
- R2: A producer allocation leaves the synonym's slot empty. A later lookup of that synonym with no rename mapping returns kind 0 until a value is written.
- R3: A value write to a resident synonym fills its slot. Later lookups return kind 1 with that data until the slot is re-allocated or evicted. A write to a synonym that has no slot is ignored.
- R4: The set is given by the low SET_W bits of the synonym and the tag by the rest. An allocation of a resident synonym reuses its way and empties it. Otherwise the allocation takes way 0 if that way is free, then way 1 if it is free. When both ways are full, the allocation replaces the way that was not the most recent allocation in that set.
- R5: An allocation that carries a register writes a rename entry mapping synonym to register. If the synonym is already mapped, its register is overwritten. If not, the lowest free entry is used. When every entry is in use, no mapping is recorded.
- R6: A lookup whose synonym is mapped returns kind 2 with the mapped register, even when the value store holds a filled slot for it.
- R7: A commit removes a rename entry only when both its synonym and its register match the commit. A commit with a different register leaves the mapping in place.
- R8: A value write and a lookup of the same synonym in one cycle return kind 1 with the data being written, unless a rename mapping exists. This holds only when the write finds its slot.
- R9: Within one cycle, an allocation is applied before a write, and a commit is applied before a register allocation. Lookups see the state from before the clock edge, apart from the forwarding in R8.
- R10: A cycle without a consumer request returns kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_alloc | input | 1 | Producer predicted: allocate its synonym |
| prod_syn | input | SYN_W | Synonym being allocated |
| prod_has_reg | input | 1 | Allocation also records a rename mapping |
| prod_preg | input | PREG_W | Physical register of the producer |
| prod_wr | input | 1 | Producer value available |
| prod_wr_syn | input | SYN_W | Synonym of the value write |
| prod_wr_data | input | DATA_W | Value being written |
| prod_commit | input | 1 | Producer commits |
| prod_cmt_syn | input | SYN_W | Synonym of the committing producer |
| prod_cmt_preg | input | PREG_W | Register of the committing producer |
| cons_req | input | 1 | Consumer lookup request |
| cons_syn | input | SYN_W | Synonym the consumer looks up |
| cons_kind | output | 2 | 0 none, 1 value, 2 register |
| cons_data | output | DATA_W | Speculative value when kind is 1, else 0 |
| cons_preg | output | PREG_W | Register tag when kind is 2, else 0 |

## Verification
The collisions that matter are a value write landing in the same cycle as a lookup of the same synonym, and an allocation landing in the same cycle as a write or a commit. The bench first provokes these in directed cycles: a write with a same-synonym lookup, an allocation with a write to the same synonym, and a commit with a re-allocation. It then runs a long pseudo-random stream over twelve synonyms, four sets of three tags, so that these overlaps and evictions happen constantly. Every answer is judged against a reference model held in the bench. The model applies the ordering rules stated in R8 and R9, and the bench compares the kind, value and register returned.

// File: rtl/svf_pkg.sv
package svf_pkg;
    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_VALUE = 2'd1,
        LK_REG   = 2'd2
    } lk_kind_e;
endpackage

// File: rtl/svf_value_file.sv
module svf_value_file #(
    parameter int SYN_W  = 6,
    parameter int SET_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SYN_W-1:0]  alloc_syn,
    input  logic              wr_valid,
    input  logic [SYN_W-1:0]  wr_syn,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SYN_W-1:0]  rd_syn,
    output logic              wr_hit,
    output logic              rd_full,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = SYN_W - SET_W;
    localparam int WAYS  = 2;

    typedef struct packed {
        logic              vld;
        logic              full;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        line_t [SETS-1:0][WAYS-1:0] line;
        logic  [SETS-1:0]           victim;
    } vf_t;

    vf_t st_d, st_q;

    logic [SET_W-1:0] a_set, w_set, r_set;
    logic [TAG_W-1:0] a_tag, w_tag, r_tag;
    logic [WAYS-1:0]  a_match, w_match, r_match;
    logic             a_way;

    always_comb begin
        a_set = alloc_syn[SET_W-1:0];
        a_tag = alloc_syn[SYN_W-1:SET_W];
        w_set = wr_syn[SET_W-1:0];
        w_tag = wr_syn[SYN_W-1:SET_W];
        r_set = rd_syn[SET_W-1:0];
        r_tag = rd_syn[SYN_W-1:SET_W];
        st_d  = st_q;

        // allocation: resident way, then free way, then victim
        for (int w = 0; w < WAYS; w++)
            a_match[w] = st_q.line[a_set][w].vld && (st_q.line[a_set][w].tag == a_tag);
        if (a_match[0])                       a_way = 1'b0;
        else if (a_match[1])                  a_way = 1'b1;
        else if (!st_q.line[a_set][0].vld)    a_way = 1'b0;
        else if (!st_q.line[a_set][1].vld)    a_way = 1'b1;
        else                                  a_way = st_q.victim[a_set];
        if (alloc_valid) begin
            st_d.line[a_set][a_way] = '{vld: 1'b1, full: 1'b0, tag: a_tag, data: '0};
            st_d.victim[a_set]      = ~a_way;
        end

        // value write sees the post-allocation view
        for (int w = 0; w < WAYS; w++)
            w_match[w] = st_d.line[w_set][w].vld && (st_d.line[w_set][w].tag == w_tag);
        wr_hit = wr_valid && (|w_match);
        for (int w = 0; w < WAYS; w++) begin
            if (wr_valid && w_match[w]) begin
                st_d.line[w_set][w].full = 1'b1;
                st_d.line[w_set][w].data = wr_data;
            end
        end

        // read from registered state
        rd_full = 1'b0;
        rd_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            r_match[w] = st_q.line[r_set][w].vld && (st_q.line[r_set][w].tag == r_tag);
            if (r_match[w] && st_q.line[r_set][w].full) begin
                rd_full = 1'b1;
                rd_data = st_q.line[r_set][w].data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    function automatic logic [DATA_W+1:0] probe(input vf_t s, input logic [SYN_W-1:0] syn);
        logic [DATA_W+1:0] r;
        r = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (s.line[syn[SET_W-1:0]][w].vld && s.line[syn[SET_W-1:0]][w].tag == syn[SYN_W-1:SET_W])
                r = {1'b1, s.line[syn[SET_W-1:0]][w].full, s.line[syn[SET_W-1:0]][w].data};
        end
        return r;
    endfunction

    logic              pa_chk_q, pw_chk_q;
    logic [SYN_W-1:0]  pa_syn_q, pw_syn_q;
    logic [DATA_W-1:0] pw_data_q;
    logic [DATA_W+1:0] pa_probe, pw_probe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_chk_q  <= 1'b0;
            pw_chk_q  <= 1'b0;
            pa_syn_q  <= '0;
            pw_syn_q  <= '0;
            pw_data_q <= '0;
        end else begin
            pa_chk_q  <= alloc_valid && !(wr_valid && wr_syn == alloc_syn);
            pa_syn_q  <= alloc_syn;
            pw_chk_q  <= wr_hit;
            pw_syn_q  <= wr_syn;
            pw_data_q <= wr_data;
        end
    end

    always_comb begin
        pa_probe = probe(st_q, pa_syn_q);
        pw_probe = probe(st_q, pw_syn_q);
    end

    a_r2_alloc_leaves_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pa_chk_q |-> (pa_probe[DATA_W+1] && !pa_probe[DATA_W]));

    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        pw_chk_q |-> (pw_probe[DATA_W+1] && pw_probe[DATA_W] && pw_probe[DATA_W-1:0] == pw_data_q));

    for (genvar s = 0; s < SETS; s++) begin : g_set_chk
        a_r4_one_way_per_tag: assert property (@(posedge clk) disable iff (!rst_n)
            !(st_q.line[s][0].vld && st_q.line[s][1].vld && st_q.line[s][0].tag == st_q.line[s][1].tag));
    end
endmodule

// File: rtl/svf_rename_map.sv
module svf_rename_map #(
    parameter int SYN_W  = 6,
    parameter int PREG_W = 6,
    parameter int MAP_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SYN_W-1:0]  alloc_syn,
    input  logic [PREG_W-1:0] alloc_preg,
    input  logic              cmt_valid,
    input  logic [SYN_W-1:0]  cmt_syn,
    input  logic [PREG_W-1:0] cmt_preg,
    input  logic [SYN_W-1:0]  rd_syn,
    output logic              rd_hit,
    output logic [PREG_W-1:0] rd_preg
);
    localparam int IDX_W = (MAP_N > 1) ? $clog2(MAP_N) : 1;

    typedef struct packed {
        logic              vld;
        logic [SYN_W-1:0]  syn;
        logic [PREG_W-1:0] preg;
    } ent_t;

    typedef struct packed {
        ent_t [MAP_N-1:0] ent;
    } rm_t;

    rm_t st_d, st_q;

    logic             same_found, free_found;
    logic [IDX_W-1:0] same_idx, free_idx;

    always_comb begin
        st_d = st_q;

        // commit first: only an exact synonym/register match is released
        for (int i = 0; i < MAP_N; i++) begin
            if (cmt_valid && st_d.ent[i].vld && st_d.ent[i].syn == cmt_syn &&
                st_d.ent[i].preg == cmt_preg)
                st_d.ent[i].vld = 1'b0;
        end

        same_found = 1'b0;
        same_idx   = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < MAP_N; i++) begin
            if (st_d.ent[i].vld && st_d.ent[i].syn == alloc_syn && !same_found) begin
                same_found = 1'b1;
                same_idx   = IDX_W'(i);
            end
            if (!st_d.ent[i].vld && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        if (alloc_valid) begin
            if (same_found)
                st_d.ent[same_idx].preg = alloc_preg;
            else if (free_found)
                st_d.ent[free_idx] = '{vld: 1'b1, syn: alloc_syn, preg: alloc_preg};
        end

        rd_hit  = 1'b0;
        rd_preg = '0;
        for (int i = 0; i < MAP_N; i++) begin
            if (st_q.ent[i].vld && st_q.ent[i].syn == rd_syn) begin
                rd_hit  = 1'b1;
                rd_preg = st_q.ent[i].preg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    logic              pc_chk_q;
    logic [SYN_W-1:0]  pc_syn_q;
    logic [PREG_W-1:0] pc_preg_q;
    logic              pc_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_chk_q  <= 1'b0;
            pc_syn_q  <= '0;
            pc_preg_q <= '0;
        end else begin
            pc_chk_q  <= cmt_valid && !(alloc_valid && alloc_syn == cmt_syn);
            pc_syn_q  <= cmt_syn;
            pc_preg_q <= cmt_preg;
        end
    end

    always_comb begin
        pc_left = 1'b0;
        for (int i = 0; i < MAP_N; i++)
            if (st_q.ent[i].vld && st_q.ent[i].syn == pc_syn_q && st_q.ent[i].preg == pc_preg_q)
                pc_left = 1'b1;
    end

    a_r7_commit_releases: assert property (@(posedge clk) disable iff (!rst_n)
        pc_chk_q |-> !pc_left);

    for (genvar i = 0; i < MAP_N; i++) begin : g_ua
        for (genvar j = i + 1; j < MAP_N; j++) begin : g_ub
            a_r5_single_mapping: assert property (@(posedge clk) disable iff (!rst_n)
                !(st_q.ent[i].vld && st_q.ent[j].vld && st_q.ent[i].syn == st_q.ent[j].syn));
        end
    end
endmodule

// File: rtl/synonym_value_store.sv
module synonym_value_store #(
    parameter int SYN_W  = 6,
    parameter int SET_W  = 2,
    parameter int DATA_W = 16,
    parameter int PREG_W = 6,
    parameter int MAP_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_alloc,
    input  logic [SYN_W-1:0]  prod_syn,
    input  logic              prod_has_reg,
    input  logic [PREG_W-1:0] prod_preg,
    input  logic              prod_wr,
    input  logic [SYN_W-1:0]  prod_wr_syn,
    input  logic [DATA_W-1:0] prod_wr_data,
    input  logic              prod_commit,
    input  logic [SYN_W-1:0]  prod_cmt_syn,
    input  logic [PREG_W-1:0] prod_cmt_preg,
    input  logic              cons_req,
    input  logic [SYN_W-1:0]  cons_syn,
    output logic [1:0]        cons_kind,
    output logic [DATA_W-1:0] cons_data,
    output logic [PREG_W-1:0] cons_preg
);
    import svf_pkg::*;

    logic              vf_wr_hit, vf_full, map_hit;
    logic [DATA_W-1:0] vf_data;
    logic [PREG_W-1:0] map_preg;
    logic              fwd;
    lk_kind_e          kind_c;

    svf_value_file #(.SYN_W(SYN_W), .SET_W(SET_W), .DATA_W(DATA_W)) u_vf (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (prod_alloc),
        .alloc_syn   (prod_syn),
        .wr_valid    (prod_wr),
        .wr_syn      (prod_wr_syn),
        .wr_data     (prod_wr_data),
        .rd_syn      (cons_syn),
        .wr_hit      (vf_wr_hit),
        .rd_full     (vf_full),
        .rd_data     (vf_data)
    );

    svf_rename_map #(.SYN_W(SYN_W), .PREG_W(PREG_W), .MAP_N(MAP_N)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (prod_alloc && prod_has_reg),
        .alloc_syn   (prod_syn),
        .alloc_preg  (prod_preg),
        .cmt_valid   (prod_commit),
        .cmt_syn     (prod_cmt_syn),
        .cmt_preg    (prod_cmt_preg),
        .rd_syn      (cons_syn),
        .rd_hit      (map_hit),
        .rd_preg     (map_preg)
    );

    always_comb begin
        fwd       = vf_wr_hit && (prod_wr_syn == cons_syn);
        kind_c    = LK_NONE;
        cons_data = '0;
        cons_preg = '0;
        if (cons_req) begin
            if (map_hit) begin
                kind_c    = LK_REG;
                cons_preg = map_preg;
            end else if (fwd) begin
                kind_c    = LK_VALUE;
                cons_data = prod_wr_data;
            end else if (vf_full) begin
                kind_c    = LK_VALUE;
                cons_data = vf_data;
            end
        end
        cons_kind = kind_c;
    end
endmodule

// File: tb/tb_synonym_value_store.sv
module tb_synonym_value_store;
    localparam int SYN_W = 6, SET_W = 2, DATA_W = 16, PREG_W = 6, MAP_N = 4;
    localparam int SETS = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic prod_alloc = 0, prod_has_reg = 0, prod_wr = 0, prod_commit = 0, cons_req = 0;
    logic [SYN_W-1:0] prod_syn = '0, prod_wr_syn = '0, prod_cmt_syn = '0, cons_syn = '0;
    logic [PREG_W-1:0] prod_preg = '0, prod_cmt_preg = '0;
    logic [DATA_W-1:0] prod_wr_data = '0;
    logic [1:0] cons_kind;
    logic [DATA_W-1:0] cons_data;
    logic [PREG_W-1:0] cons_preg;

    int checks = 0, fails = 0;
    logic [31:0] rs = 32'h1234_abcd;

    always #2.5 clk = ~clk;

    synonym_value_store #(.SYN_W(SYN_W), .SET_W(SET_W), .DATA_W(DATA_W), .PREG_W(PREG_W), .MAP_N(MAP_N)) dut (
        .clk(clk), .rst_n(rst_n), .prod_alloc(prod_alloc), .prod_syn(prod_syn),
        .prod_has_reg(prod_has_reg), .prod_preg(prod_preg), .prod_wr(prod_wr),
        .prod_wr_syn(prod_wr_syn), .prod_wr_data(prod_wr_data), .prod_commit(prod_commit),
        .prod_cmt_syn(prod_cmt_syn), .prod_cmt_preg(prod_cmt_preg), .cons_req(cons_req),
        .cons_syn(cons_syn), .cons_kind(cons_kind), .cons_data(cons_data), .cons_preg(cons_preg));

    // reference model: value store and rename map
    logic mv[SETS][2], mf[SETS][2], mvic[SETS];
    logic [3:0] mt[SETS][2];
    logic [15:0] md[SETS][2];
    logic qv[MAP_N];
    logic [5:0] qs[MAP_N], qp[MAP_N];

    function automatic logic [31:0] nxt();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic step(input bit a, input int asyn, input bit ahr, input int apreg,
                        input bit w, input int wsyn, input int wdata,
                        input bit c, input int csyn, input int cpreg,
                        input bit l, input int lsyn, input string tag);
        logic nv[SETS][2], nf[SETS][2], nvic[SETS];
        logic [3:0] nt[SETS][2];
        logic [15:0] nd[SETS][2];
        logic nqv[MAP_N];
        logic [5:0] nqs[MAP_N], nqp[MAP_N];
        int as, at, ws, wt, way, ls, lt;
        bit whit, found;
        int ek, ed, ep;
        string t;
        prod_alloc = a; prod_syn = 6'(asyn); prod_has_reg = ahr; prod_preg = 6'(apreg);
        prod_wr = w; prod_wr_syn = 6'(wsyn); prod_wr_data = 16'(wdata);
        prod_commit = c; prod_cmt_syn = 6'(csyn); prod_cmt_preg = 6'(cpreg);
        cons_req = l; cons_syn = 6'(lsyn);
        nv = mv; nf = mf; nvic = mvic; nt = mt; nd = md; nqv = qv; nqs = qs; nqp = qp;
        as = asyn % 4; at = asyn / 4;
        if (a) begin
            if (mv[as][0] && mt[as][0] == 4'(at)) way = 0;
            else if (mv[as][1] && mt[as][1] == 4'(at)) way = 1;
            else if (!mv[as][0]) way = 0;
            else if (!mv[as][1]) way = 1;
            else way = int'(mvic[as]);
            nv[as][way] = 1; nf[as][way] = 0; nt[as][way] = 4'(at); nd[as][way] = 0;
            nvic[as] = (way == 0);
        end
        ws = wsyn % 4; wt = wsyn / 4; whit = 0;
        if (w) for (int k = 0; k < 2; k++)
            if (nv[ws][k] && nt[ws][k] == 4'(wt)) begin
                whit = 1; nf[ws][k] = 1; nd[ws][k] = 16'(wdata);
            end
        if (c) for (int i = 0; i < MAP_N; i++)
            if (nqv[i] && nqs[i] == 6'(csyn) && nqp[i] == 6'(cpreg)) nqv[i] = 0;
        if (a && ahr) begin
            found = 0;
            for (int i = 0; i < MAP_N; i++)
                if (!found && nqv[i] && nqs[i] == 6'(asyn)) begin found = 1; nqp[i] = 6'(apreg); end
            for (int i = 0; i < MAP_N; i++)
                if (!found && !nqv[i]) begin found = 1; nqv[i] = 1; nqs[i] = 6'(asyn); nqp[i] = 6'(apreg); end
        end
        // expected answer from pre-edge state
        ek = 0; ed = 0; ep = 0;
        if (l) begin
            found = 0;
            for (int i = 0; i < MAP_N; i++)
                if (qv[i] && qs[i] == 6'(lsyn)) begin found = 1; ep = int'(qp[i]); end
            if (found) ek = 2;
            else if (w && wsyn == lsyn && whit) begin ek = 1; ed = wdata & 16'hffff; end
            else begin
                ls = lsyn % 4; lt = lsyn / 4;
                for (int k = 0; k < 2; k++)
                    if (mv[ls][k] && mt[ls][k] == 4'(lt) && mf[ls][k]) begin ek = 1; ed = int'(md[ls][k]); end
            end
        end
        t = tag;
        if (t == "") t = (ek == 2) ? "R6" : (ek == 1) ? "R3" : "R2";
        #1;
        checks++;
        if (int'(cons_kind) != ek || (ek == 1 && int'(cons_data) != ed) || (ek == 2 && int'(cons_preg) != ep)) begin
            fails++;
            $display("FAIL %s syn=%0d actual kind=%0d data=%0d preg=%0d expected kind=%0d data=%0d preg=%0d",
                     t, lsyn, cons_kind, cons_data, cons_preg, ek, ed, ep);
        end
        @(posedge clk);
        mv = nv; mf = nf; mvic = nvic; mt = nt; md = nd; qv = nqv; qs = nqs; qp = nqp;
        @(negedge clk);
    endtask

    task automatic look(input int s, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            mvic[s] = 0;
            for (int k = 0; k < 2; k++) begin mv[s][k] = 0; mf[s][k] = 0; mt[s][k] = 0; md[s][k] = 0; end
        end
        for (int i = 0; i < MAP_N; i++) begin qv[i] = 0; qs[i] = 0; qp[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        for (int s = 0; s < 64; s++) look(s, "R1");
        step(1, 5, 1, 9, 0, 0, 0, 0, 0, 0, 0, 5, "R10");   // R10: no request -> kind 0
        step(0, 0, 0, 0, 1, 5, 77, 0, 0, 0, 0, 5, "R10");
        look(5, "R6");
        step(0, 0, 0, 0, 0, 0, 0, 1, 5, 9, 0, 0, "R7");
        look(5, "R3");

        // R4: fill every set with every tag, checking placement and eviction
        for (int s = 0; s < 64; s++) step(1, s, 0, 0, 0, 0, 0, 0, 0, 0, 1, (s + 60) % 64, "R4");
        for (int s = 0; s < 64; s++) look(s, "R2");
        // R8: write and same-synonym lookup in one cycle
        for (int s = 0; s < 64; s++) step(0, 0, 0, 0, 1, s, s * 37 + 5, 0, 0, 0, 1, s, "R8");
        for (int s = 0; s < 64; s++) look(s, "R3");
        // R4: re-allocation of resident empties it; next allocation evicts the other way
        step(1, 60, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        look(60, "R4");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        look(56, "R4"); look(0, "R4"); look(60, "R4");

        // R5 / R6: mappings, overwrite, capacity
        for (int i = 1; i <= 6; i++) step(1, 56 + i, 1, 10 + i, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        for (int i = 1; i <= 6; i++) look(56 + i, "R5");
        step(0, 0, 0, 0, 1, 57, 999, 0, 0, 0, 1, 57, "R6");
        look(57, "R6");
        step(1, 58, 1, 40, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        look(58, "R5");
        // R7: commit with stale register keeps, exact one releases
        step(0, 0, 0, 0, 0, 0, 0, 1, 58, 12, 1, 58, "R7");
        look(58, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 1, 58, 40, 0, 0, "R7");
        look(58, "R7");
        step(0, 0, 0, 0, 1, 58, 321, 0, 0, 0, 0, 0, "R7");
        look(58, "R7");
        // R9: allocate and write same synonym in one cycle; commit and re-allocate in one cycle
        step(1, 33, 0, 0, 1, 33, 4242, 0, 0, 0, 1, 33, "R9");
        look(33, "R9");
        step(1, 57, 1, 50, 0, 0, 0, 1, 57, 11, 1, 57, "R9");
        look(57, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, 57, 50, 0, 0, "R9");
        look(57, "R9");

        // random stream over twelve synonyms
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r0, r1;
            r0 = nxt(); r1 = nxt();
            step(r0[0] & r0[1], int'(r0[7:4]) % 12, r0[2], int'(r0[13:8]),
                 r0[3] | r0[14], int'(r0[19:16]) % 12, int'(r1[15:0]),
                 r0[20] & r0[21], int'(r0[25:22]) % 12, int'(r1[21:16]),
                 r0[26] | r0[27], int'(r1[27:24]) % 12, "");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule